// File: doc/BRIEF.md
# Secure memory region access filter

This block guards a memory port. Every request from the bus master is checked in the same cycle against a small set of programmable address windows. A window is a power-of-two span placed at a size-aligned base, with an enable and four permission bits that treat secure and non-secure reads and writes apart. An allowed request goes straight on to the memory; a refused one is held back from the memory and answered with zero data.

A response is produced one clock after every request. On a refusal a two-bit action setting decides whether the response carries a bus error, whether an interrupt is raised, both, or neither. The first refusal is recorded with its address, direction and security state. A refusal that comes while one is still pending only marks an overrun. Software programs the windows and clears the record through a word-addressed register port with combinational read-back.

Top module: `memwin_filter`

## Requirements
- R1: Every cycle with `req_valid` high is followed one clock later by `rsp_valid` high; a cycle without a request gives `rsp_valid` low one clock later.
- R2: An allowed request drives `mem_valid` high in its own cycle with the request's address, direction and write data; for an allowed read, `rsp_rdata` in the response cycle equals the `mem_rdata` seen in the request cycle.
- R3: A refused request keeps `mem_valid` low, and its response carries `rsp_rdata` equal to zero (writes also answer with zero data).
- R4: Window n is set by its base (low word at offset 0x100+16n, upper address bits at 0x104+16n) and a size code c in attribute bits [6:1]; it covers 2^(c+1) bytes, and an address hits when all address bits above bit c equal the base.
- R5: Attribute bit 0 enables a window; a window with bit 0 clear hits nothing (window 0 excepted).
- R6: Window 0 always hits and is the background; when several windows hit, the one with the highest index supplies the permissions.
- R7: Attribute bit 28 allows non-secure writes, bit 29 non-secure reads, bit 30 secure writes, bit 31 secure reads; a request is allowed only when its bit is set in the deciding window.
- R8: The action register (offset 0x004, bits [1:0]) reads 0 after reset: bit 0 set makes a refused request's response carry `rsp_err`, and bit 1 set drives `irq` high while a failure is pending; code 0 signals nothing, 1 error only, 2 interrupt only, 3 both.
- R9: A refusal while nothing is pending sets status bit 0 (offset 0x010) and captures the address (low word at 0x020, upper bits at 0x024) and a control word at 0x028 with bit 0 = write and bit 1 = secure; later refusals leave the capture unchanged.
- R10: A refusal while status bit 0 is already set sets status bit 1 (overrun).
- R11: Writing 1 to bit 0 of offset 0x014 clears both status bits in the next clock and drops `irq`.
- R12: The window base and attribute registers read back the value written, upper base bits zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_secure | input | 1 | Request is secure |
| req_addr | input | AW | Request byte address |
| req_wdata | input | DW | Request write data |
| mem_valid | output | 1 | Forwarded request to memory |
| mem_write | output | 1 | Forwarded direction |
| mem_addr | output | AW | Forwarded address |
| mem_wdata | output | DW | Forwarded write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Response carries a bus error |
| rsp_rdata | output | DW | Response read data |
| irq | output | 1 | Failure interrupt |

## Verification
The bench goes after overlapping windows, where a filter that let the lowest index decide would grant a non-secure write into a read-only sub-window. It probes the first address below and the last address inside a window and an address that differs only in the upper base bits, which a wrong size mask or a dropped upper base word would hit or miss in error. A disabled window is shown to fall back to the background, a second refusal must leave the captured address alone and only raise the overrun, and every action code is run so that mixed-up error and interrupt bits show up as a wrong `rsp_err` or `irq`.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
   localparam logic [11:0] OFF_ACTION = 12'h004;
   localparam logic [11:0] OFF_STATUS = 12'h010;
   localparam logic [11:0] OFF_CLEAR  = 12'h014;
   localparam logic [11:0] OFF_FLO    = 12'h020;
   localparam logic [11:0] OFF_FHI    = 12'h024;
   localparam logic [11:0] OFF_FCTL   = 12'h028;
   localparam logic [3:0]  WIN_PAGE   = 4'h1;

   // permission nibble: [0] ns write, [1] ns read, [2] s write, [3] s read
   function automatic logic perm_allows(input logic [3:0] perm,
                                        input logic wr, input logic sec);
      logic [1:0] sel;
      sel = {sec, ~wr};
      return perm[sel];
   endfunction
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
   import memwin_pkg::*;
#(
   parameter int NREG = 4,
   parameter int AW   = 36
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_wr,
   input  logic [11:0]               cfg_addr,
   input  logic [31:0]               cfg_wdata,
   output logic [31:0]               cfg_rdata,
   output logic [NREG-1:0][AW-1:0]   base_o,
   output logic [NREG-1:0][5:0]      code_o,
   output logic [NREG-1:0]           en_o,
   output logic [NREG-1:0][3:0]      perm_o,
   output logic [1:0]                act_o,
   output logic                      pend_o,
   output logic                      ovr_o,
   output logic                      clr_o,
   output logic [AW-1:0]             cap_addr_o,
   input  logic                      fail_ev,
   input  logic [AW-1:0]             fail_addr,
   input  logic                      fail_wr,
   input  logic                      fail_sec
);
   localparam int HIW = AW - 32;

   logic [NREG-1:0][AW-1:0] base_q;
   logic [NREG-1:0][31:0]   attr_q;
   logic [1:0]              act_q;
   logic                    pend_q, ovr_q, cap_wr_q, cap_sec_q;
   logic [AW-1:0]           cap_q;

   logic       win_sel;
   logic [3:0] ridx;
   logic [1:0] rsub;
   logic       clr, pend_left;

   assign ridx      = cfg_addr[7:4];
   assign rsub      = cfg_addr[3:2];
   assign win_sel   = (cfg_addr[11:8] == WIN_PAGE) && (int'(ridx) < NREG)
                      && (cfg_addr[1:0] == 2'b00);
   assign clr       = cfg_wr && (cfg_addr == OFF_CLEAR) && cfg_wdata[0];
   assign pend_left = pend_q && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         attr_q    <= '0;
         act_q     <= '0;
         pend_q    <= 1'b0;
         ovr_q     <= 1'b0;
         cap_q     <= '0;
         cap_wr_q  <= 1'b0;
         cap_sec_q <= 1'b0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (cfg_wr && win_sel && (ridx == 4'(i))) begin
               case (rsub)
                  2'd0:    base_q[i][31:0]   <= cfg_wdata;
                  2'd1:    base_q[i][AW-1:32] <= cfg_wdata[HIW-1:0];
                  2'd2:    attr_q[i]         <= cfg_wdata;
                  default: ;
               endcase
            end
         end
         if (cfg_wr && (cfg_addr == OFF_ACTION))
            act_q <= cfg_wdata[1:0];
         pend_q <= pend_left || fail_ev;
         ovr_q  <= (ovr_q && !clr) || (fail_ev && pend_left);
         if (fail_ev && !pend_left) begin
            cap_q     <= fail_addr;
            cap_wr_q  <= fail_wr;
            cap_sec_q <= fail_sec;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (win_sel) begin
         for (int i = 0; i < NREG; i++) begin
            if (ridx == 4'(i)) begin
               case (rsub)
                  2'd0:    cfg_rdata = base_q[i][31:0];
                  2'd1:    cfg_rdata = 32'(base_q[i][AW-1:32]);
                  2'd2:    cfg_rdata = attr_q[i];
                  default: cfg_rdata = '0;
               endcase
            end
         end
      end else begin
         case (cfg_addr)
            OFF_ACTION: cfg_rdata = {30'd0, act_q};
            OFF_STATUS: cfg_rdata = {30'd0, ovr_q, pend_q};
            OFF_FLO:    cfg_rdata = cap_q[31:0];
            OFF_FHI:    cfg_rdata = 32'(cap_q[AW-1:32]);
            OFF_FCTL:   cfg_rdata = {30'd0, cap_sec_q, cap_wr_q};
            default:    cfg_rdata = '0;
         endcase
      end
   end

   always_comb begin
      for (int i = 0; i < NREG; i++) begin
         code_o[i] = attr_q[i][6:1];
         en_o[i]   = attr_q[i][0];
         perm_o[i] = attr_q[i][31:28];
      end
   end

   assign base_o     = base_q;
   assign act_o      = act_q;
   assign pend_o     = pend_q;
   assign ovr_o      = ovr_q;
   assign clr_o      = clr;
   assign cap_addr_o = cap_q;
endmodule

// File: rtl/memwin_match.sv
module memwin_match #(
   parameter int AW    = 36,
   parameter bit IS_BG = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [5:0]    code,
   input  logic          en,
   output logic          hit
);
   logic [AW-1:0] keep;
   logic          same;

   always_comb begin
      for (int b = 0; b < AW; b++)
         keep[b] = (b > int'(code));
   end

   assign same = (((addr ^ base) & keep) == '0);
   assign hit  = IS_BG | (en & same);
endmodule

// File: rtl/memwin_pick.sv
module memwin_pick
   import memwin_pkg::*;
#(
   parameter int NREG = 4
) (
   input  logic [NREG-1:0]      hits,
   input  logic [NREG-1:0][3:0] perms,
   input  logic                 wr,
   input  logic                 sec,
   output logic                 allow
);
   logic [3:0] chosen;

   always_comb begin
      chosen = 4'd0;
      for (int i = 0; i < NREG; i++)
         if (hits[i]) chosen = perms[i];
   end

   assign allow = perm_allows(chosen, wr, sec);
endmodule

// File: rtl/memwin_filter.sv
module memwin_filter
   import memwin_pkg::*;
#(
   parameter int NREG = 4,
   parameter int AW   = 36,
   parameter int DW   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [11:0]   cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_secure,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          mem_valid,
   output logic          mem_write,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [DW-1:0] rsp_rdata,
   output logic          irq
);
   generate
      if (NREG < 1 || NREG > 16) begin : g_bad_nreg
         $error("NREG must lie in 1..16");
      end
      if (AW < 33 || AW > 64) begin : g_bad_aw
         $error("AW must lie in 33..64");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic [NREG-1:0][AW-1:0] base_w;
   logic [NREG-1:0][5:0]    code_w;
   logic [NREG-1:0]         en_w;
   logic [NREG-1:0][3:0]    perm_w;
   logic [NREG-1:0]         hit_w;
   logic [1:0]              act_q;
   logic                    pend_q, ovr_q, clr_ev, allow, fail_ev;
   logic [AW-1:0]           cap_addr;

   assign fail_ev = req_valid && !allow;

   memwin_regs #(.NREG(NREG), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .base_o(base_w), .code_o(code_w), .en_o(en_w), .perm_o(perm_w),
      .act_o(act_q), .pend_o(pend_q), .ovr_o(ovr_q), .clr_o(clr_ev),
      .cap_addr_o(cap_addr),
      .fail_ev(fail_ev), .fail_addr(req_addr),
      .fail_wr(req_write), .fail_sec(req_secure)
   );

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_win
         memwin_match #(.AW(AW), .IS_BG(g == 0)) u_match (
            .addr(req_addr), .base(base_w[g]), .code(code_w[g]),
            .en(en_w[g]), .hit(hit_w[g])
         );
      end
   endgenerate

   memwin_pick #(.NREG(NREG)) u_pick (
      .hits(hit_w), .perms(perm_w), .wr(req_write), .sec(req_secure),
      .allow(allow)
   );

   assign mem_valid = req_valid && allow;
   assign mem_write = req_write;
   assign mem_addr  = req_addr;
   assign mem_wdata = req_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= fail_ev && act_q[0];
         rsp_rdata <= (mem_valid && !req_write) ? mem_rdata : '0;
      end
   end

   assign irq = pend_q && act_q[1];
endmodule

// File: rtl/memwin_filter_chk.sv
module memwin_filter_chk #(
   parameter int AW = 36,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          mem_valid,
   input logic          mem_write,
   input logic          rsp_valid,
   input logic          rsp_err,
   input logic [DW-1:0] rsp_rdata,
   input logic          irq,
   input logic [1:0]    act_q,
   input logic          pend_q,
   input logic          ovr_q,
   input logic          clr_ev,
   input logic          fail_ev,
   input logic [AW-1:0] cap_addr
);
   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R1
   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R1
   AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_rdata != '0) |-> $past(mem_valid && !mem_write)); // R3
   AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_valid && !mem_valid)); // R3
   AST_ERR_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(act_q[0])); // R8
   AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pend_q); // R8
   AST_OVR_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> pend_q); // R10
   AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend_q) && !$past(clr_ev)) |-> $stable(cap_addr)); // R9
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_ev) && !$past(fail_ev)) |-> (!pend_q && !ovr_q)); // R11
endmodule

bind memwin_filter memwin_filter_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_valid(mem_valid),
   .mem_write(mem_write), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
   .rsp_rdata(rsp_rdata), .irq(irq), .act_q(act_q), .pend_q(pend_q),
   .ovr_q(ovr_q), .clr_ev(clr_ev), .fail_ev(fail_ev), .cap_addr(cap_addr)
);

// File: tb/memwin_filter_test.sv
`timescale 1ns/1ps
module memwin_filter_test;
   localparam int AW = 36;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [11:0]   cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          mem_valid, mem_write;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          rsp_valid, rsp_err, irq;
   logic [DW-1:0] rsp_rdata;

   int   checks = 0;
   int   errors = 0;
   logic [1:0] act_b = 2'd0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   assign mem_rdata = mem_addr[31:0] ^ 32'h5A5A_0000;

   memwin_filter #(.NREG(4), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .irq(irq)
   );

   // bits: 39 write, 38 secure, 37 expected grant, 35:0 address
   localparam int NV = 11;
   localparam logic [39:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b1, 1'b0, 36'h0_0001_0000},
      {1'b1, 1'b0, 1'b1, 1'b0, 36'h0_0001_7FFC},
      {1'b1, 1'b0, 1'b0, 1'b0, 36'h0_0001_8000},
      {1'b0, 1'b0, 1'b1, 1'b0, 36'h0_0001_8004},
      {1'b0, 1'b1, 1'b0, 1'b0, 36'h0_0001_8004},
      {1'b0, 1'b1, 1'b1, 1'b0, 36'h0_0002_0000},
      {1'b1, 1'b0, 1'b0, 1'b0, 36'h0_0002_0000},
      {1'b0, 1'b0, 1'b0, 1'b0, 36'h0_0004_0000},
      {1'b0, 1'b1, 1'b1, 1'b0, 36'h0_0004_0000},
      {1'b0, 1'b0, 1'b0, 1'b0, 36'h1_0001_0000},
      {1'b1, 1'b1, 1'b1, 1'b0, 36'h0_0000_FFFC}
   };

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [11:0] a, input logic [31:0] exp,
                         input string tag);
      @(negedge clk);
      cfg_addr = a;
      #1;
      check(tag, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic access(input logic w, input logic s, input logic [AW-1:0] a,
                         input logic grant, input string tag);
      logic [31:0] exp_data;
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_secure = s; req_addr = a;
      req_wdata = 32'hC0DE_0000 | 32'(a[15:0]);
      #1;
      check({tag, " R2/R3 mem_valid"}, 64'(mem_valid), 64'(grant));
      if (grant) check({tag, " R2 mem_addr"}, 64'(mem_addr), 64'(a));
      exp_data = (grant && !w) ? (a[31:0] ^ 32'h5A5A_0000) : 32'd0;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
      check({tag, " R8 rsp_err"}, 64'(rsp_err), 64'(!grant && act_b[0]));
      check({tag, " R2/R3 rsp_rdata"}, 64'(rsp_rdata), 64'(exp_data));
   endtask

   initial begin : watchdog
      int n;
      n = 0;
      while (!done && n < 100000) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
      check("R8 reset irq", 64'(irq), 64'd0);
      check("R3 reset mem_valid", 64'(mem_valid), 64'd0);
      rst_n = 1'b1;
      rd_reg(12'h010, 32'h0, "R9 reset status");
      rd_reg(12'h004, 32'h0, "R8 reset action");
      @(negedge clk);
      check("R1 idle rsp_valid", 64'(rsp_valid), 64'd0);

      wr_reg(12'h108, 32'hC000_0000);               // background: secure rw
      wr_reg(12'h110, 32'h0001_0000);
      wr_reg(12'h118, 32'hF000_001F);               // 64 KiB, all
      wr_reg(12'h120, 32'h0001_8000);
      wr_reg(12'h128, 32'h2000_001D);               // 32 KiB, ns read only
      wr_reg(12'h130, 32'h0004_0000);
      wr_reg(12'h138, 32'hF000_001C);               // disabled

      for (int v = 0; v < NV; v++) begin
         access(VEC[v][39], VEC[v][38], VEC[v][35:0], VEC[v][37],
                $sformatf("R4/R6/R7 vec%0d", v));
      end

      rd_reg(12'h010, 32'h3, "R10 status overrun");
      rd_reg(12'h020, 32'h0001_8000, "R9 fail low");
      rd_reg(12'h024, 32'h0, "R9 fail high");
      rd_reg(12'h028, 32'h1, "R9 fail ctrl");
      check("R8 code0 irq", 64'(irq), 64'd0);

      wr_reg(12'h014, 32'h1);
      rd_reg(12'h010, 32'h0, "R11 status cleared");

      wr_reg(12'h004, 32'h1); act_b = 2'd1;
      access(1'b1, 1'b0, 36'h0_0002_0000, 1'b0, "R8 code1");
      check("R8 code1 irq", 64'(irq), 64'd0);
      wr_reg(12'h014, 32'h1);

      wr_reg(12'h004, 32'h2); act_b = 2'd2;
      access(1'b0, 1'b1, 36'h0_0001_8004, 1'b0, "R8 code2");
      check("R8 code2 irq", 64'(irq), 64'd1);
      rd_reg(12'h028, 32'h2, "R9 ctrl secure read");
      rd_reg(12'h020, 32'h0001_8004, "R9 fail low 2");
      rd_reg(12'h010, 32'h1, "R9 status single");
      wr_reg(12'h014, 32'h1);
      check("R11 irq dropped", 64'(irq), 64'd0);

      wr_reg(12'h004, 32'h3); act_b = 2'd3;
      access(1'b1, 1'b0, 36'h0_0002_0000, 1'b0, "R8 code3");
      check("R8 code3 irq", 64'(irq), 64'd1);
      wr_reg(12'h014, 32'h1);

      wr_reg(12'h128, 32'h2000_001C);               // disable window 2
      access(1'b1, 1'b0, 36'h0_0001_8000, 1'b1, "R5 disabled falls back");
      access(1'b0, 1'b0, 36'h0_0000_FFFC, 1'b0, "R4 below window");
      access(1'b0, 1'b0, 36'h0_0001_FFFC, 1'b1, "R4 last inside");

      wr_reg(12'h130, 32'h0);
      wr_reg(12'h134, 32'h1);
      wr_reg(12'h138, 32'hF000_001D);
      access(1'b0, 1'b0, 36'h1_0000_0000, 1'b1, "R4 upper base hit");
      access(1'b0, 1'b0, 36'h1_0000_8000, 1'b0, "R4 just outside");

      rd_reg(12'h118, 32'hF000_001F, "R12 attr readback");
      rd_reg(12'h134, 32'h1, "R12 high readback");
      rd_reg(12'h110, 32'h0001_0000, "R12 low readback");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule